// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external static RAM whose storage cells are level-sensitive latches with no clock. The host hands over one read or one write at a time on a valid/ready request channel. The controller then plays out the chip-select, write-enable and output-enable waveforms that the RAM needs. Each phase of those waveforms lasts a whole number of clock cycles, set by a parameter.

A write runs in three phases. In the setup phase the address and data are placed on the pins while the RAM is still deselected. In the pulse phase chip select and write enable are held low together. In the hold phase both are raised again while the address and data stay where they are. The RAM therefore stores whatever data is on the bus when the write condition falls.

A read lowers chip select and output enable for an access phase, with the controller's data drive switched off. At the end of that phase the controller registers the returned data. One clock of completion strobe follows every operation.

Back-pressure works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole of the operation, and the host must hold its request stable while it waits. The completion strobe cannot be stalled: the host must accept it in the cycle it appears.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are held at these values: `req_ready`=1, `rsp_valid`=0, `rsp_rdata`=0, `mem_cs_n`=`mem_we_n`=`mem_oe_n`=1 (all active low, so 1 means inactive), `mem_dq_oe`=0 and `mem_addr`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_write`=1 selects a write and 0 selects a read. After acceptance, `req_ready` is 0 until the operation completes, and the request inputs have no effect during that time.
- R3: After a write is accepted, the pins go through three phases. First, T_ASU cycles with `mem_cs_n`=`mem_we_n`=1 and `mem_dq_oe`=1. Next, exactly T_WP cycles with `mem_cs_n`=`mem_we_n`=0. Last, T_HOLD cycles with both back at 1 and `mem_dq_oe` still 1.
- R4: `mem_addr` and `mem_dq_o` take the accepted address and data in the cycle after acceptance. They do not change until the next request is accepted.
- R5: After a read is accepted, `mem_cs_n`=`mem_oe_n`=0 and `mem_we_n`=1 for exactly T_ACC cycles, with `mem_dq_oe`=0. `mem_dq_i` is sampled at the clock edge that ends the last of those cycles.
- R6: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0, and it is 0 whenever the controller is idle.
- R7: `rsp_valid` is 1 for exactly one cycle. For a write, that cycle comes T_ASU+T_WP+T_HOLD cycles after the acceptance edge; for a read, T_ACC cycles after it. `rsp_rdata` changes only when a read completes, and keeps its value through writes.
- R8: `req_ready` returns to 1 in the same cycle as `rsp_valid`. The next request can be accepted at the very next edge, so operations can run back to back with no gap.
- R9: A read returns the last value written to that address, which is the value on the data pins when the write condition ended. An address never written returns the RAM's initial content.
- R10: `mem_we_n` is 0 only while `mem_cs_n` is 0 and `mem_oe_n` is 1. `mem_oe_n` is 0 only while `mem_cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DW | Data from the last completed read |
| mem_addr | output | AW | RAM address pins |
| mem_dq_o | output | DW | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_i | input | DW | Data returned by the RAM |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench drives several request patterns:
- Single operations separated by idle gaps, which expose every phase boundary on its own.
- Back-to-back requests held valid under back-pressure, which show whether the controller accepts exactly at the ready cycle and ignores the waiting request.
- Write-then-read pairs, repeated overwrites of one address, reads of never-written cells, and accesses at the lowest and highest addresses. Together these separate correct storage from stale data, wrong addresses, or data that changed before the latch closed.

A reference model in the bench predicts every pin on every cycle, so a phase that is one cycle too long or too short is reported at the exact cycle where it goes wrong.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSETUP  = 3'd1,
    PH_WPULSE  = 3'd2,
    PH_WHOLD   = 3'd3,
    PH_RACCESS = 3'd4
  } phase_e;

  // Any phase length below one cycle is raised to one.
  function automatic int unsigned at_least_one(int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int unsigned cnt_bits(int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer import sram_ctrl_pkg::*; #(
  parameter int unsigned MAX_LEN = 4,
  parameter int unsigned CW      = cnt_bits(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_remain,
  output logic          expired
);

  logic [CW-1:0] remain_q;

  // Holds the number of cycles left in the current phase, minus one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain_q <= '0;
    else if (load)
      remain_q <= load_remain;
    else if (remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_wdata
);

  // Address and data stay frozen from acceptance until the next acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_wdata <= '0;
    end else if (capture) begin
      out_addr  <= in_addr;
      out_wdata <= in_wdata;
    end
  end

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive import sram_ctrl_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_nxt,
  output logic   cs_n,
  output logic   we_n,
  output logic   oe_n,
  output logic   dq_oe
);

  // Strobes come straight from flops decoded from the next phase, so the
  // RAM never sees a decode glitch on a latch enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      cs_n  <= !((phase_nxt == PH_WPULSE) || (phase_nxt == PH_RACCESS));
      we_n  <= (phase_nxt != PH_WPULSE);
      oe_n  <= (phase_nxt != PH_RACCESS);
      dq_oe <= (phase_nxt == PH_WSETUP) || (phase_nxt == PH_WPULSE) ||
               (phase_nxt == PH_WHOLD);
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl import sram_ctrl_pkg::*; #(
  parameter int unsigned AW     = 10,
  parameter int unsigned DW     = 16,
  parameter int unsigned T_ASU  = 1,
  parameter int unsigned T_WP   = 2,
  parameter int unsigned T_HOLD = 1,
  parameter int unsigned T_ACC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  localparam int unsigned PH_ASU  = at_least_one(T_ASU);
  localparam int unsigned PH_WP   = at_least_one(T_WP);
  localparam int unsigned PH_HOLD = at_least_one(T_HOLD);
  localparam int unsigned PH_ACC  = at_least_one(T_ACC);
  localparam int unsigned MAX_LEN = max4(PH_ASU, PH_WP, PH_HOLD, PH_ACC);
  localparam int unsigned CW      = cnt_bits(MAX_LEN);

  localparam logic [CW-1:0] REM_ASU  = CW'(PH_ASU - 1);
  localparam logic [CW-1:0] REM_WP   = CW'(PH_WP - 1);
  localparam logic [CW-1:0] REM_HOLD = CW'(PH_HOLD - 1);
  localparam logic [CW-1:0] REM_ACC  = CW'(PH_ACC - 1);

  phase_e        phase_q, phase_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_remain;
  logic          tmr_expired;
  logic          accept;
  logic          finish;
  logic          grab_read;

  // Next-phase logic. The timer is reloaded on every phase entry.
  always_comb begin
    phase_d    = phase_q;
    tmr_load   = 1'b0;
    tmr_remain = '0;
    accept     = 1'b0;
    finish     = 1'b0;
    grab_read  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            phase_d    = PH_WSETUP;
            tmr_remain = REM_ASU;
          end else begin
            phase_d    = PH_RACCESS;
            tmr_remain = REM_ACC;
          end
        end
      end
      PH_WSETUP: begin
        if (tmr_expired) begin
          phase_d    = PH_WPULSE;
          tmr_load   = 1'b1;
          tmr_remain = REM_WP;
        end
      end
      PH_WPULSE: begin
        if (tmr_expired) begin
          phase_d    = PH_WHOLD;
          tmr_load   = 1'b1;
          tmr_remain = REM_HOLD;
        end
      end
      PH_WHOLD: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      PH_RACCESS: begin
        if (tmr_expired) begin
          phase_d   = PH_IDLE;
          finish    = 1'b1;
          grab_read = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= PH_IDLE;
    else
      phase_q <= phase_d;
  end

  assign req_ready = (phase_q == PH_IDLE);

  sram_phase_timer #(
    .MAX_LEN (MAX_LEN),
    .CW      (CW)
  ) timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (tmr_load),
    .load_remain (tmr_remain),
    .expired     (tmr_expired)
  );

  sram_req_hold #(
    .AW (AW),
    .DW (DW)
  ) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .out_addr  (mem_addr),
    .out_wdata (mem_dq_o)
  );

  sram_pin_drive pins_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_nxt (phase_d),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  // Read data is captured at the edge that closes the access phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish;
      if (grab_read)
        rsp_rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk import sram_ctrl_pkg::*; #(
  parameter int unsigned AW   = 10,
  parameter int unsigned DW   = 16,
  parameter int unsigned T_WP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  localparam int unsigned PH_WP = at_least_one(T_WP);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      we_low_cnt <= '0;
    else if (!mem_we_n)
      we_low_cnt <= we_low_cnt + 16'd1;
    else
      we_low_cnt <= '0;
  end

  assert_we_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_cs_n);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_read_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

  assert_addr_stable_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  assert_hold_after_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(PH_WP)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  assert_idle_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .AW   (AW),
  .DW   (DW),
  .T_WP (T_WP)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/async_sram_model.sv
module async_sram_model #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n
);

  logic [DW-1:0] cells [2**AW];
  logic          wr_on;

  initial begin
    for (int i = 0; i < 2**AW; i++) cells[i] = DW'(i * 37 + 5);
  end

  assign wr_on = !cs_n && !we_n;

  // Latch cell: the value present when the write condition closes is kept.
  always @(negedge wr_on) cells[a] = d;

  assign q = (!cs_n && !oe_n) ? cells[a] : '0;

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TA = 2;
  localparam int TW = 3;
  localparam int TH = 2;
  localparam int TR = 3;
  localparam int N  = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_i;
  logic          mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] ram_d;

  always #5 clk = ~clk;

  assign ram_d = mem_dq_oe ? mem_dq_o : '0;

  async_sram_model #(.AW(AW), .DW(DW)) ram_i (
    .a(mem_addr), .d(ram_d), .q(mem_dq_i),
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n)
  );

  sram_cycle_ctrl #(
    .AW(AW), .DW(DW), .T_ASU(TA), .T_WP(TW), .T_HOLD(TH), .T_ACC(TR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n)
  );

  typedef struct {
    bit            rdy;
    bit            cs_n;
    bit            we_n;
    bit            oe_n;
    bit            dq_oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit            rv;
    logic [DW-1:0] rd;
  } pins_t;

  pins_t         exp_q[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  logic [DW-1:0] shadow [2**AW];
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_rd = '0;
  bit            op_w   [N];
  logic [AW-1:0] op_a   [N];
  logic [DW-1:0] op_d   [N];
  int            op_gap [N];

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  // Reference model: lays out every cycle of one operation in advance.
  task automatic plan_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    pins_t p;
    p = '{rdy:1'b0, cs_n:1'b1, we_n:1'b1, oe_n:1'b1, dq_oe:w, a:a, d:d, rv:1'b0, rd:last_rd};
    if (w) begin
      repeat (TA) exp_q.push_back(p);
      p.cs_n = 1'b0; p.we_n = 1'b0;
      repeat (TW) exp_q.push_back(p);
      p.cs_n = 1'b1; p.we_n = 1'b1;
      repeat (TH) exp_q.push_back(p);
      shadow[a] = d;
    end else begin
      p.cs_n = 1'b0; p.oe_n = 1'b0;
      repeat (TR) exp_q.push_back(p);
      last_rd = shadow[a];
    end
    last_a = a;
    p = '{rdy:1'b1, cs_n:1'b1, we_n:1'b1, oe_n:1'b1, dq_oe:1'b0, a:a, d:d, rv:1'b1, rd:last_rd};
    exp_q.push_back(p);
  endtask

  task automatic set_op(int i, bit w, int a, int d, int g);
    op_w[i] = w; op_a[i] = AW'(a); op_d[i] = DW'(d); op_gap[i] = g;
  endtask

  initial begin
    pins_t e;
    int    idx;
    int    gap;
    int    cyc;
    bit    acc_pending;

    for (int i = 0; i < 2**AW; i++) shadow[i] = DW'(i * 37 + 5);
    set_op(0,  1, 5,   'hA5A5, 2);
    set_op(1,  1, 6,   'h1234, 0);
    set_op(2,  0, 5,   0,      0);
    set_op(3,  0, 6,   0,      3);
    set_op(4,  0, 77,  0,      0);   // never written: initial content
    set_op(5,  1, 255, 'hFFFF, 1);   // highest address
    set_op(6,  0, 255, 0,      0);
    set_op(7,  1, 0,   'h0000, 0);   // lowest address
    set_op(8,  0, 0,   0,      0);
    set_op(9,  1, 5,   'hC3C3, 0);
    set_op(10, 1, 5,   'h3C3C, 0);   // overwrite
    set_op(11, 0, 5,   0,      0);
    for (int k = 0; k < 12; k++) begin
      if (k % 2 == 0) set_op(12 + k, 1, 8 + k * 19, k * 4099 + 7, k % 3);
      else            set_op(12 + k, 0, 8 + (k - 1) * 19, 0, k % 3);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "rsp_rdata", rsp_rdata, 0);
    chk("R1", "cs/we/oe",  {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk("R1", "dq_oe",     mem_dq_oe, 0);
    chk("R1", "mem_addr",  mem_addr, 0);
    rst_n = 1'b1;

    idx = 0; gap = op_gap[0]; cyc = 0; acc_pending = 0;
    while (idx < N || exp_q.size() != 0 || acc_pending) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected <= 20000", cyc);
        break;
      end
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else e = '{rdy:1'b1, cs_n:1'b1, we_n:1'b1, oe_n:1'b1, dq_oe:1'b0, a:last_a, d:'0, rv:1'b0, rd:last_rd};

      chk("R2/R8", "req_ready", req_ready, e.rdy);
      chk("R3/R10", "mem_cs_n", mem_cs_n, e.cs_n);
      chk("R3/R10", "mem_we_n", mem_we_n, e.we_n);
      chk("R5", "mem_oe_n", mem_oe_n, e.oe_n);
      chk("R6", "mem_dq_oe", mem_dq_oe, e.dq_oe);
      chk("R4", "mem_addr", mem_addr, e.a);
      if (e.dq_oe) chk("R4", "mem_dq_o", mem_dq_o, e.d);
      chk("R7", "rsp_valid", rsp_valid, e.rv);
      chk("R9", "rsp_rdata", rsp_rdata, e.rd);

      if (acc_pending) begin
        req_valid = 1'b0;
        acc_pending = 0;
      end
      if (!req_valid && idx < N) begin
        if (gap > 0) gap--;
        else begin
          req_write = op_w[idx];
          req_addr  = op_a[idx];
          req_wdata = op_d[idx];
          req_valid = 1'b1;
        end
      end
      if (req_valid && e.rdy) begin
        plan_op(op_w[idx], op_a[idx], op_d[idx]);
        idx++;
        if (idx < N) gap = op_gap[idx];
        acc_pending = 1;
      end
    end

    repeat (3) begin
      @(negedge clk);
      chk("R6", "idle dq_oe", mem_dq_oe, 0);
      chk("R7", "idle rsp_valid", rsp_valid, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule